// File: doc/BRIEF.md
# CAN Controller Mode and Flag Registers

This block is the software-facing control and status register set of a CAN controller. A simple register bus (write enable, 4-bit address, byte data, combinational read data) reaches a small set of byte registers. These registers request initialization or sleep mode, report when each mode has been entered, hold the bit-timing and acceptance-filter setup, and carry the receive and transmit-buffer flags that drive one interrupt line.

The protocol engine itself is outside the block. It reports to this block through single-cycle event strobes and an idle level. In return it receives per-buffer transmit requests, the selected buffer index, and enables for driving the bus and for acceptance filtering. Mode changes always follow a request/acknowledge handshake. Software sets a request bit and then polls the matching acknowledge bit, which moves only when the engine is idle.

Top module: `can_mode_regs`

Register addresses:

| Address | Contents |
|---|---|
| 0 | Mode request: bit 0 init, bit 1 sleep |
| 1 | Status and options: bit 0 init ack, bit 1 sleep ack, bit 2 loopback, bit 3 listen-only, bit 4 engine idle, bit 5 synchronized |
| 2 | Timing 0 |
| 3 | Timing 1 |
| 4 | Filter setup |
| 5 | Receive flags |
| 6 | Receive interrupt enables |
| 7 | Transmit flags |
| 8 | Transmit interrupt enables |
| 9 | Buffer select |

## Requirements
- R1: After reset, the mode request and acknowledge bits are 0 and the receive flags are 0. The transmit flags (address 7) read all ones, irq_o is 0 and drive_en_o is 1.
- R2: The init acknowledge (address 1, bit 0) follows the init request (address 0, bit 0). It changes no earlier than the second clock edge after the request register changes, and only on an edge where idle_i is high. This applies both to entering and to leaving initialization mode.
- R3: While init acknowledge is 1, tx_req_o is all zero, every transmit flag is forced to 1 (transmission aborted), and filter_en_o is 0.
- R4: The sleep request (address 0, bit 1) and sleep acknowledge (address 1, bit 1) follow the same handshake as R2. A wake_evt_i strobe sets the wake flag (address 5, bit 2) only while sleep acknowledge is 1. Outside sleep, the strobe is ignored.
- R5: The receive flags at address 5 are rx-full (bit 0), overrun (bit 1), wake (bit 2), error (bit 3) and bus-off (bit 4). Each is set by its event strobe. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R6: Outside initialization mode, writing 0 to a bit of the transmit flags at address 7 clears that flag, and tx_req_o for that buffer goes high. Writing 1 has no effect. A tx_done_i strobe sets the flag back to 1.
- R7: The buffer select register at address 9 (low bits) drives buf_sel_o and can be written at any time.
- R8: The timing registers (addresses 2 and 3), the filter setup (address 4) and the option bits (address 1, bits 2 and 3) accept writes only while init acknowledge is 1. Writes at other times are ignored.
- R9: loopback_o and listen_o reflect option bits 2 and 3. drive_en_o is 1 only when listen-only is off and neither init nor sleep acknowledge is set.
- R10: irq_o is the OR of the receive flags ANDed with the receive enables (address 6), together with the transmit flags ANDed with the transmit enables (address 8).
- R11: synced_o (address 1, bit 5) is set by a sync_evt_i strobe only outside init and sleep, and is cleared whenever init or sleep acknowledge is 1. Address 1, bit 4 mirrors idle_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| idle_i | input | 1 | Protocol engine idle |
| sync_evt_i | input | 1 | Engine reached bus synchronization |
| rx_full_evt_i | input | 1 | Frame received strobe |
| overrun_evt_i | input | 1 | Receive overrun strobe |
| wake_evt_i | input | 1 | Bus activity wake strobe |
| error_evt_i | input | 1 | Error state change strobe |
| busoff_evt_i | input | 1 | Bus-off strobe |
| tx_done_i | input | NBUF | Per-buffer transmit finished or aborted |
| tx_req_o | output | NBUF | Per-buffer transmit request |
| buf_sel_o | output | SELW | Buffer addressed by the data window |
| loopback_o | output | 1 | Internal loopback selected |
| listen_o | output | 1 | Listen-only selected |
| drive_en_o | output | 1 | Engine may drive the bus |
| filter_en_o | output | 1 | Acceptance filtering active |
| synced_o | output | 1 | Bus synchronized |
| btr0_o | output | 8 | Timing register 0 |
| btr1_o | output | 8 | Timing register 1 |
| filt_cfg_o | output | 8 | Filter setup register |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle and must be resolved correctly. A hardware flag event and a software write-1 clear of the same bit can coincide. A software transmit request and a hardware buffer-done can also coincide. The bench provokes the first case by driving rx_full_evt_i in the very cycle that all receive flags are written with ones. It then judges the result by reading rx-full as 1 while the other cleared flags read 0. The same pattern checks that tx_done_i wins over a concurrent write of 0 to that buffer's flag.

// File: rtl/can_mode_pkg.sv
`timescale 1ns/1ps
package can_mode_pkg;
  localparam int unsigned AW    = 4;
  localparam int unsigned RXF_W = 5;

  typedef enum logic [AW-1:0] {
    A_MODE = 4'd0,
    A_STAT = 4'd1,
    A_TIM0 = 4'd2,
    A_TIM1 = 4'd3,
    A_FILT = 4'd4,
    A_RXF  = 4'd5,
    A_RXIE = 4'd6,
    A_TXF  = 4'd7,
    A_TXIE = 4'd8,
    A_BSEL = 4'd9
  } reg_addr_e;

  // receive flag bit positions
  localparam int unsigned F_RXFULL = 0;
  localparam int unsigned F_OVR    = 1;
  localparam int unsigned F_WAKE   = 2;
  localparam int unsigned F_ERR    = 3;
  localparam int unsigned F_BOFF   = 4;
endpackage

// File: rtl/can_mode_hs.sv
`timescale 1ns/1ps
// Request/acknowledge handshake: ack follows a registered copy of req, only while idle.
module can_mode_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic idle_i,
  output logic ack_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      req_q <= req_i;
      if (idle_i && (req_q != ack_o)) ack_o <= req_q;
    end
  end

  // R2/R4: acknowledge moves only on an idle edge
  p_ack_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ack_o) |-> $past(idle_i));
  // R2: two-edge lag on entry
  p_ack_rise_lag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(req_i, 2) && $past(req_i)));
  // R2: two-edge lag on exit
  p_ack_fall_lag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(req_i, 2) && !$past(req_i)));
endmodule

// File: rtl/can_mode_flags.sv
`timescale 1ns/1ps
// Flag vector: hardware set, software clear, set has priority.
module can_mode_flags #(
  parameter int unsigned   W       = 5,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= RST_VAL;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end

  // R5/R6: an event is never lost to a concurrent clear
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
  // R5/R6: a clear without event leaves the bit low
  p_clear_takes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
  // R5/R6: no bit rises without its event
  p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/can_mode_regs.sv
`timescale 1ns/1ps
module can_mode_regs
  import can_mode_pkg::*;
#(
  parameter int unsigned NBUF = 3,
  parameter int unsigned DW   = 8,
  localparam int unsigned SELW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            idle_i,
  input  logic            sync_evt_i,
  input  logic            rx_full_evt_i,
  input  logic            overrun_evt_i,
  input  logic            wake_evt_i,
  input  logic            error_evt_i,
  input  logic            busoff_evt_i,
  input  logic [NBUF-1:0] tx_done_i,
  output logic [NBUF-1:0] tx_req_o,
  output logic [SELW-1:0] buf_sel_o,
  output logic            loopback_o,
  output logic            listen_o,
  output logic            drive_en_o,
  output logic            filter_en_o,
  output logic            synced_o,
  output logic [DW-1:0]   btr0_o,
  output logic [DW-1:0]   btr1_o,
  output logic [DW-1:0]   filt_cfg_o,
  output logic            irq_o
);
  logic init_req_q, sleep_req_q, init_ack, sleep_ack;
  logic [RXF_W-1:0] rxf, rx_set, rx_clr, rx_ien_q;
  logic [NBUF-1:0]  txf, tx_set, tx_clr, tx_ien_q;

  function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
    return a == r;
  endfunction

  wire cfg_open = init_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_req_q  <= 1'b0;
      sleep_req_q <= 1'b0;
      loopback_o  <= 1'b0;
      listen_o    <= 1'b0;
      btr0_o      <= '0;
      btr1_o      <= '0;
      filt_cfg_o  <= '0;
      rx_ien_q    <= '0;
      tx_ien_q    <= '0;
      buf_sel_o   <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, A_MODE)) begin
        init_req_q  <= wdata_i[0];
        sleep_req_q <= wdata_i[1];
      end
      if (hit(addr_i, A_STAT) && cfg_open) begin
        loopback_o <= wdata_i[2];
        listen_o   <= wdata_i[3];
      end
      if (hit(addr_i, A_TIM0) && cfg_open) btr0_o     <= wdata_i;
      if (hit(addr_i, A_TIM1) && cfg_open) btr1_o     <= wdata_i;
      if (hit(addr_i, A_FILT) && cfg_open) filt_cfg_o <= wdata_i;
      if (hit(addr_i, A_RXIE)) rx_ien_q  <= wdata_i[RXF_W-1:0];
      if (hit(addr_i, A_TXIE)) tx_ien_q  <= wdata_i[NBUF-1:0];
      if (hit(addr_i, A_BSEL)) buf_sel_o <= wdata_i[SELW-1:0];
    end
  end

  can_mode_hs u_init_hs (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(init_req_q), .idle_i(idle_i), .ack_o(init_ack)
  );
  can_mode_hs u_sleep_hs (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(sleep_req_q), .idle_i(idle_i), .ack_o(sleep_ack)
  );

  // bus synchronization tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     synced_o <= 1'b0;
    else if (init_ack || sleep_ack)  synced_o <= 1'b0;
    else if (sync_evt_i)             synced_o <= 1'b1;
  end

  always_comb begin
    rx_set           = '0;
    rx_set[F_RXFULL] = rx_full_evt_i;
    rx_set[F_OVR]    = overrun_evt_i;
    rx_set[F_WAKE]   = wake_evt_i && sleep_ack;
    rx_set[F_ERR]    = error_evt_i;
    rx_set[F_BOFF]   = busoff_evt_i;
    rx_clr = (wr_en_i && hit(addr_i, A_RXF)) ? wdata_i[RXF_W-1:0] : '0;
  end

  can_mode_flags #(.W(RXF_W), .RST_VAL('0)) u_rx_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rx_set), .clr_i(rx_clr), .flags_o(rxf)
  );

  // transmit side: writing 0 requests, init aborts everything
  assign tx_set = tx_done_i | {NBUF{init_ack}};
  assign tx_clr = (wr_en_i && hit(addr_i, A_TXF) && !init_ack) ? ~wdata_i[NBUF-1:0] : '0;

  can_mode_flags #(.W(NBUF), .RST_VAL({NBUF{1'b1}})) u_tx_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(tx_set), .clr_i(tx_clr), .flags_o(txf)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_txreq
    assign tx_req_o[b] = !txf[b] && !init_ack;
  end

  assign drive_en_o  = !init_ack && !sleep_ack && !listen_o;
  assign filter_en_o = !init_ack && !sleep_ack;
  assign irq_o       = (|(rxf & rx_ien_q)) | (|(txf & tx_ien_q));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE: rdata_o[1:0] = {sleep_req_q, init_req_q};
      A_STAT: rdata_o[5:0] = {synced_o, idle_i, listen_o, loopback_o, sleep_ack, init_ack};
      A_TIM0: rdata_o = btr0_o;
      A_TIM1: rdata_o = btr1_o;
      A_FILT: rdata_o = filt_cfg_o;
      A_RXF:  rdata_o[RXF_W-1:0] = rxf;
      A_RXIE: rdata_o[RXF_W-1:0] = rx_ien_q;
      A_TXF:  rdata_o[NBUF-1:0]  = txf;
      A_TXIE: rdata_o[NBUF-1:0]  = tx_ien_q;
      A_BSEL: rdata_o[SELW-1:0]  = buf_sel_o;
      default: rdata_o = '0;
    endcase
  end

  // R8: locked configuration ignores writes
  p_cfg_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit(addr_i, A_TIM0) && !init_ack) |=> $stable(btr0_o));
  // R3: entering init leaves every buffer empty
  p_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_ack) |=> (txf == {NBUF{1'b1}}));
  // R11: synchronization is dropped under init or sleep
  p_sync_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_ack || sleep_ack) |=> !synced_o);
  // R9: listen-only never drives
  p_listen_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    listen_o |-> !drive_en_o);
  // R4: wake outside sleep cannot raise the wake flag
  p_wake_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_ack && !rxf[F_WAKE]) |=> !rxf[F_WAKE]);
endmodule

// File: tb/can_mode_regs_test.sv
`timescale 1ns/1ps
module can_mode_regs_test;
  localparam int NBUF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic idle = 1'b1, sync_evt = 1'b0, rxfull_evt = 1'b0, ovr_evt = 1'b0;
  logic wake_evt = 1'b0, err_evt = 1'b0, boff_evt = 1'b0;
  logic [NBUF-1:0] tx_done = '0, tx_req;
  logic [1:0] buf_sel;
  logic loopback, listen, drive_en, filter_en, synced, irq;
  logic [7:0] btr0, btr1, filt;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  can_mode_regs #(.NBUF(NBUF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .idle_i(idle), .sync_evt_i(sync_evt), .rx_full_evt_i(rxfull_evt),
    .overrun_evt_i(ovr_evt), .wake_evt_i(wake_evt), .error_evt_i(err_evt),
    .busoff_evt_i(boff_evt), .tx_done_i(tx_done), .tx_req_o(tx_req), .buf_sel_o(buf_sel),
    .loopback_o(loopback), .listen_o(listen), .drive_en_o(drive_en),
    .filter_en_o(filter_en), .synced_o(synced), .btr0_o(btr0), .btr1_o(btr1),
    .filt_cfg_o(filt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic enter_init();
    wr(4'd0, 8'h01);
    repeat (3) @(negedge clk);
  endtask

  task automatic leave_init();
    wr(4'd0, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 mode", 4'd0, 8'h00);
    rd_chk("R1 stat", 4'd1, 8'h10);
    rd_chk("R1 rxf", 4'd5, 8'h00);
    rd_chk("R1 txf", 4'd7, 8'h07);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 drive", {7'd0, drive_en}, 8'd1);
  endtask

  task automatic t_init_hs();
    logic [7:0] d;
    wr(4'd0, 8'h01);
    rd(4'd1, d); chk("R2 lag0", {7'd0, d[0]}, 8'd0);
    @(negedge clk); rd(4'd1, d); chk("R2 lag1", {7'd0, d[0]}, 8'd0);
    @(negedge clk); rd(4'd1, d); chk("R2 ack", {7'd0, d[0]}, 8'd1);
    chk("R3 filter off", {7'd0, filter_en}, 8'd0);
    wr(4'd0, 8'h00);
    rd(4'd1, d); chk("R2 exit lag0", {7'd0, d[0]}, 8'd1);
    @(negedge clk); rd(4'd1, d); chk("R2 exit lag1", {7'd0, d[0]}, 8'd1);
    @(negedge clk); rd(4'd1, d); chk("R2 exit", {7'd0, d[0]}, 8'd0);
    // busy engine holds acknowledge
    idle = 1'b0;
    wr(4'd0, 8'h01);
    repeat (4) @(negedge clk);
    rd(4'd1, d); chk("R2 wait idle", {7'd0, d[0]}, 8'd0);
    idle = 1'b1;
    @(negedge clk);
    rd(4'd1, d); chk("R2 idle ack", {7'd0, d[0]}, 8'd1);
    leave_init();
  endtask

  task automatic t_cfg_lock();
    wr(4'd2, 8'h5A);
    rd_chk("R8 tim0 locked", 4'd2, 8'h00);
    wr(4'd1, 8'h0C);
    rd_chk("R8 opts locked", 4'd1, 8'h10);
    enter_init();
    wr(4'd2, 8'h5A); wr(4'd3, 8'hC3); wr(4'd4, 8'h21); wr(4'd1, 8'h04);
    rd_chk("R8 tim0", 4'd2, 8'h5A);
    rd_chk("R8 tim1", 4'd3, 8'hC3);
    rd_chk("R8 filt", 4'd4, 8'h21);
    chk("R9 loopback", {7'd0, loopback}, 8'd1);
    wr(4'd1, 8'h00);
    leave_init();
    wr(4'd3, 8'h00);
    rd_chk("R8 tim1 kept", 4'd3, 8'hC3);
  endtask

  task automatic t_listen();
    enter_init();
    wr(4'd1, 8'h08);
    leave_init();
    chk("R9 listen", {7'd0, listen}, 8'd1);
    chk("R9 no drive", {7'd0, drive_en}, 8'd0);
    enter_init();
    wr(4'd1, 8'h00);
    leave_init();
    chk("R9 drive back", {7'd0, drive_en}, 8'd1);
  endtask

  task automatic t_tx();
    wr(4'd7, 8'hFD);
    rd_chk("R6 request", 4'd7, 8'h05);
    chk("R6 txreq", {5'd0, tx_req}, 8'h02);
    wr(4'd7, 8'hFF);
    rd_chk("R6 one ignored", 4'd7, 8'h05);
    @(negedge clk); tx_done = 3'b010; @(negedge clk); tx_done = '0;
    rd_chk("R6 done", 4'd7, 8'h07);
    chk("R6 req drop", {5'd0, tx_req}, 8'h00);
    // done and request on same buffer in one cycle: done wins
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd7; wdata = 8'hFB; tx_done = 3'b100;
    @(negedge clk);
    wr_en = 1'b0; tx_done = '0;
    rd_chk("R6 done wins", 4'd7, 8'h07);
    // abort on init
    wr(4'd7, 8'hFE);
    chk("R6 req0", {5'd0, tx_req}, 8'h01);
    enter_init();
    rd_chk("R3 abort flags", 4'd7, 8'h07);
    chk("R3 no req", {5'd0, tx_req}, 8'h00);
    wr(4'd7, 8'h00);
    rd_chk("R3 init blocks req", 4'd7, 8'h07);
    leave_init();
  endtask

  task automatic t_bsel();
    wr(4'd9, 8'h02);
    chk("R7 bsel", {6'd0, buf_sel}, 8'd2);
    rd_chk("R7 bsel read", 4'd9, 8'h02);
    wr(4'd9, 8'h01);
    chk("R7 bsel 1", {6'd0, buf_sel}, 8'd1);
  endtask

  task automatic t_rx();
    @(negedge clk); rxfull_evt = 1'b1; err_evt = 1'b1; @(negedge clk);
    rxfull_evt = 1'b0; err_evt = 1'b0;
    rd_chk("R5 set", 4'd5, 8'h09);
    wr(4'd5, 8'h00);
    rd_chk("R5 zero write", 4'd5, 8'h09);
    wr(4'd5, 8'h08);
    rd_chk("R5 w1c", 4'd5, 8'h01);
    @(negedge clk); ovr_evt = 1'b1; boff_evt = 1'b1; @(negedge clk);
    ovr_evt = 1'b0; boff_evt = 1'b0;
    rd_chk("R5 ovr boff", 4'd5, 8'h13);
    // clear all while rx-full event lands: event wins
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd5; wdata = 8'hFF; rxfull_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rxfull_evt = 1'b0;
    rd_chk("R5 set wins", 4'd5, 8'h01);
    wr(4'd5, 8'hFF);
    rd_chk("R5 clear all", 4'd5, 8'h00);
  endtask

  task automatic t_sleep();
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    rd_chk("R4 wake ignored", 4'd5, 8'h00);
    wr(4'd0, 8'h02);
    repeat (3) @(negedge clk);
    rd_chk("R4 sleep ack", 4'd1, 8'h12);
    chk("R4 no drive", {7'd0, drive_en}, 8'd0);
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    rd_chk("R4 wake flag", 4'd5, 8'h04);
    wr(4'd0, 8'h00);
    repeat (3) @(negedge clk);
    rd_chk("R4 sleep exit", 4'd1, 8'h10);
    wr(4'd5, 8'h04);
  endtask

  task automatic t_sync();
    @(negedge clk); sync_evt = 1'b1; @(negedge clk); sync_evt = 1'b0;
    chk("R11 synced", {7'd0, synced}, 8'd1);
    rd_chk("R11 stat", 4'd1, 8'h30);
    enter_init();
    chk("R11 drop", {7'd0, synced}, 8'd0);
    @(negedge clk); sync_evt = 1'b1; @(negedge clk); sync_evt = 1'b0;
    chk("R11 held in init", {7'd0, synced}, 8'd0);
    leave_init();
    idle = 1'b0;
    rd_chk("R11 idle bit", 4'd1, 8'h00);
    idle = 1'b1;
  endtask

  task automatic t_irq();
    wr(4'd6, 8'h10);
    chk("R10 masked quiet", {7'd0, irq}, 8'd0);
    @(negedge clk); boff_evt = 1'b1; @(negedge clk); boff_evt = 1'b0;
    chk("R10 rx irq", {7'd0, irq}, 8'd1);
    wr(4'd5, 8'h10);
    chk("R10 rx cleared", {7'd0, irq}, 8'd0);
    @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    chk("R10 disabled src", {7'd0, irq}, 8'd0);
    wr(4'd5, 8'h08);
    wr(4'd6, 8'h00);
    wr(4'd8, 8'h01);
    chk("R10 tx empty irq", {7'd0, irq}, 8'd1);
    wr(4'd7, 8'hFE);
    chk("R10 tx busy", {7'd0, irq}, 8'd0);
    @(negedge clk); tx_done = 3'b001; @(negedge clk); tx_done = '0;
    chk("R10 tx back", {7'd0, irq}, 8'd1);
    wr(4'd8, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_hs();
    t_cfg_lock();
    t_listen();
    t_tx();
    t_bsel();
    t_rx();
    t_sleep();
    t_sync();
    t_irq();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule